// File: doc/BRIEF.md
# Internal Data Operand Address Resolver

This block turns one operand specifier of an 8-bit microcontroller instruction into a physical access target. The specifier has an addressing mode, an operand byte, and the register-bank select bits of the current program state. The target is either a location in internal data RAM or a location in the special-function register (SFR) space. The instruction decoder presents one request per cycle. The register file supplies the contents of the two pointer registers of the active bank. One cycle later the resolver returns the target address and a one-hot pair of selects that route the access to RAM or to the SFR fabric.

Three addressing modes are resolved:

- **Register operands.** These name one of eight registers. The resolver relocates them into the active bank, and banks sit eight bytes apart.
- **Direct operands.** The upper half of the byte range goes to SFRs and the lower half goes to RAM.
- **Register-indirect operands.** These take their address from one of the two pointer registers. They always reach RAM, including the upper 128 bytes that a direct access would send to SFRs.

The fourth mode code is reserved and produces no result.

Top module: `opnd_target_resolver`

## Requirements
- R1: While `rst` is high at a rising clock edge, and in the cycle after it, `out_valid`, `ram_sel` and `sfr_sel` are 0 and `tgt_addr` is 0x00. This holds even if a request was pending.
- R2: `req_mode` is encoded as 2'b00 register, 2'b01 direct, 2'b10 register-indirect and 2'b11 reserved.
- R3: In register mode the result address is {3'b000, bank_sel[1:0], req_operand[2:0]} and `ram_sel` is 1. Bits 7:3 of `req_operand` have no effect.
- R4: In direct mode with an operand from 0x00 to 0x7F, the result address equals the operand and `ram_sel` is 1.
- R5: In direct mode with an operand from 0x80 to 0xFF, the result address equals the operand and `sfr_sel` is 1.
- R6: In register-indirect mode, `req_operand[0]` = 0 selects `ptr_r0` and 1 selects `ptr_r1`. The result address is that pointer value, and `ram_sel` is 1 for every value 0x00 to 0xFF. `bank_sel` and operand bits 7:1 have no effect.
- R7: A request sampled with `req_valid` high at a rising edge produces its result at that edge. The result is visible until the next edge, with `out_valid` high. Back-to-back requests give back-to-back results.
- R8: When `out_valid` is 1, exactly one of `ram_sel` and `sfr_sel` is 1. When `out_valid` is 0, both selects are 0 and `tgt_addr` is 0x00.
- R9: A request with the reserved mode code produces a cycle with `out_valid` 0, both selects 0 and `tgt_addr` 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Addressing mode code |
| req_operand | input | 8 | Operand byte or register index |
| bank_sel | input | 2 | Active register bank |
| ptr_r0 | input | 8 | Contents of pointer register 0 of the active bank |
| ptr_r1 | input | 8 | Contents of pointer register 1 of the active bank |
| out_valid | output | 1 | Result valid |
| tgt_addr | output | 8 | Resolved target address |
| ram_sel | output | 1 | Target is internal data RAM |
| sfr_sel | output | 1 | Target is the SFR space |

## Verification
The bench builds the resolver with its default parameters: an 8-bit address, a 2-bit bank select and a 3-bit register index. With these values every bank base (0x00, 0x08, 0x10, 0x18) and both ends of each half of the direct range can be reached. So can pointer values on either side of the RAM/SFR split, which exposes the case where the same byte means an SFR under direct access but RAM under indirect access. A vector table covers each mode at these boundaries. Directed cases then cover reset with a pending request, idle cycles, back-to-back requests and the reserved mode code.

// File: rtl/opres_pkg.sv
package opres_pkg;

  typedef enum logic [1:0] {
    AM_REG = 2'b00,
    AM_DIR = 2'b01,
    AM_IND = 2'b10,
    AM_RSV = 2'b11
  } amode_e;

endpackage

// File: rtl/opres_bank_map.sv
module opres_bank_map #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr
);
  localparam int PAD_W = ADDR_W - BANK_W - IDX_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr = {{PAD_W{1'b0}}, bank, idx};
    end else begin : g_nopad
      assign addr = {bank, idx};
    end
  endgenerate
endmodule

// File: rtl/opres_direct_class.sv
module opres_direct_class #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_sfr
);
  localparam logic [ADDR_W-1:0] SFR_BASE = ADDR_W'(1) << (ADDR_W - 1);

  assign is_sfr = (addr >= SFR_BASE);
endmodule

// File: rtl/opres_ptr_pick.sv
module opres_ptr_pick #(
  parameter int ADDR_W = 8
) (
  input  logic              which,
  input  logic [ADDR_W-1:0] r0,
  input  logic [ADDR_W-1:0] r1,
  output logic [ADDR_W-1:0] ptr
);
  assign ptr = which ? r1 : r0;
endmodule

// File: rtl/opnd_target_resolver.sv
module opnd_target_resolver #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [ADDR_W-1:0] req_operand,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [ADDR_W-1:0] ptr_r0,
  input  logic [ADDR_W-1:0] ptr_r1,
  output logic              out_valid,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              ram_sel,
  output logic              sfr_sel
);
  import opres_pkg::*;

  amode_e            mode;
  logic [ADDR_W-1:0] rn_addr;
  logic [ADDR_W-1:0] ind_addr;
  logic              dir_is_sfr;
  logic              nxt_ok;
  logic [ADDR_W-1:0] nxt_addr;
  logic              nxt_ram;
  logic              nxt_sfr;

  assign mode = amode_e'(req_mode);

  opres_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .IDX_W(IDX_W)) u_bank (
    .bank (bank_sel),
    .idx  (req_operand[IDX_W-1:0]),
    .addr (rn_addr)
  );

  opres_direct_class #(.ADDR_W(ADDR_W)) u_dir (
    .addr   (req_operand),
    .is_sfr (dir_is_sfr)
  );

  opres_ptr_pick #(.ADDR_W(ADDR_W)) u_ptr (
    .which (req_operand[0]),
    .r0    (ptr_r0),
    .r1    (ptr_r1),
    .ptr   (ind_addr)
  );

  always_comb begin
    nxt_ok   = 1'b0;
    nxt_addr = '0;
    nxt_ram  = 1'b0;
    nxt_sfr  = 1'b0;
    unique case (mode)
      AM_REG: begin
        nxt_ok   = 1'b1;
        nxt_addr = rn_addr;
        nxt_ram  = 1'b1;
      end
      AM_DIR: begin
        nxt_ok   = 1'b1;
        nxt_addr = req_operand;
        nxt_ram  = ~dir_is_sfr;
        nxt_sfr  = dir_is_sfr;
      end
      AM_IND: begin
        nxt_ok   = 1'b1;
        nxt_addr = ind_addr;
        nxt_ram  = 1'b1;
      end
      default: begin
        nxt_ok = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      tgt_addr  <= '0;
      ram_sel   <= 1'b0;
      sfr_sel   <= 1'b0;
    end else if (req_valid && nxt_ok) begin
      out_valid <= 1'b1;
      tgt_addr  <= nxt_addr;
      ram_sel   <= nxt_ram;
      sfr_sel   <= nxt_sfr;
    end else begin
      out_valid <= 1'b0;
      tgt_addr  <= '0;
      ram_sel   <= 1'b0;
      sfr_sel   <= 1'b0;
    end
  end

  // Exactly one target selected for every result.
  p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({ram_sel, sfr_sel}) == 1));

  // Idle cycles carry no target.
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!ram_sel && !sfr_sel && tgt_addr == '0));

  // One-cycle latency for every accepted mode.
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode != 2'b11) |=> out_valid);

  // Reserved mode yields nothing.
  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b11) |=> !out_valid);

  // Register operands land in the active bank.
  p_bank_reloc_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b00) |=>
      (ram_sel && tgt_addr == ADDR_W'({$past(bank_sel), $past(req_operand[IDX_W-1:0])})));

  // Indirect access always reaches RAM.
  p_indirect_ram_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b10) |=> (ram_sel && !sfr_sel));

  // Direct upper half goes to SFRs; lower half to RAM.
  p_direct_split_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01) |=> (sfr_sel == tgt_addr[ADDR_W-1]));
endmodule

// File: tb/test_opnd_target_resolver.sv
module test_opnd_target_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic [7:0] req_operand = 8'h00;
  logic [1:0] bank_sel = 2'b00;
  logic [7:0] ptr_r0 = 8'h00;
  logic [7:0] ptr_r1 = 8'h00;
  logic       out_valid;
  logic [7:0] tgt_addr;
  logic       ram_sel;
  logic       sfr_sel;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  opnd_target_resolver i_opnd_target_resolver (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_operand(req_operand), .bank_sel(bank_sel), .ptr_r0(ptr_r0),
    .ptr_r1(ptr_r1), .out_valid(out_valid), .tgt_addr(tgt_addr),
    .ram_sel(ram_sel), .sfr_sel(sfr_sel)
  );

  // mode, operand, bank, r0, r1, exp_addr, exp_ram, exp_sfr, exp_valid
  localparam int NV = 14;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 8'h05, 2'd0, 8'h00, 8'h00, 8'h05, 1'b1, 1'b0, 1'b1}, // R3 bank 0
    {2'd0, 8'h03, 2'd1, 8'h00, 8'h00, 8'h0B, 1'b1, 1'b0, 1'b1}, // R3 bank 1
    {2'd0, 8'hFF, 2'd3, 8'h00, 8'h00, 8'h1F, 1'b1, 1'b0, 1'b1}, // R3 high bits ignored
    {2'd0, 8'h00, 2'd2, 8'h00, 8'h00, 8'h10, 1'b1, 1'b0, 1'b1}, // R3 bank 2 base
    {2'd1, 8'h00, 2'd3, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1}, // R4 low end
    {2'd1, 8'h7F, 2'd0, 8'h00, 8'h00, 8'h7F, 1'b1, 1'b0, 1'b1}, // R4 high end
    {2'd1, 8'h80, 2'd0, 8'h00, 8'h00, 8'h80, 1'b0, 1'b1, 1'b1}, // R5 low end
    {2'd1, 8'hFF, 2'd3, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b1}, // R5 high end
    {2'd1, 8'h81, 2'd1, 8'h00, 8'h00, 8'h81, 1'b0, 1'b1, 1'b1}, // R5
    {2'd2, 8'h00, 2'd1, 8'h90, 8'h20, 8'h90, 1'b1, 1'b0, 1'b1}, // R6 pointer 0, upper RAM
    {2'd2, 8'h01, 2'd2, 8'h90, 8'h20, 8'h20, 1'b1, 1'b0, 1'b1}, // R6 pointer 1
    {2'd2, 8'h01, 2'd3, 8'h00, 8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1}, // R6 top of RAM
    {2'd2, 8'hFE, 2'd0, 8'h80, 8'h11, 8'h80, 1'b1, 1'b0, 1'b1}, // R6 bits 7:1 ignored
    {2'd3, 8'h80, 2'd0, 8'h55, 8'h66, 8'h00, 1'b0, 1'b0, 1'b0}  // R9 reserved
  };
  localparam int VREQ [NV] = '{3, 3, 3, 3, 4, 4, 5, 5, 5, 6, 6, 6, 6, 9};

  task automatic check(input logic [10:0] exp, input string tag);
    logic [10:0] act;
    act = {out_valid, ram_sel, sfr_sel, tgt_addr};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got v/ram/sfr/addr=%b/%b/%b/%h expected %b/%b/%b/%h",
               tag, act[10], act[9], act[8], act[7:0], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic issue(input logic v, input logic [1:0] m, input logic [7:0] op,
                       input logic [1:0] b, input logic [7:0] p0, input logic [7:0] p1);
    req_valid = v; req_mode = m; req_operand = op; bank_sel = b; ptr_r0 = p0; ptr_r1 = p1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(11'h000, "R1 reset state");
    rst = 1'b0;

    // Vector table walk: R2 codes through R3..R6, R9
    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][38:37], VEC[i][36:29], VEC[i][28:27], VEC[i][26:19], VEC[i][18:11]);
      @(posedge clk); @(negedge clk);
      check({VEC[i][0], VEC[i][2], VEC[i][1], VEC[i][10:3]}, $sformatf("R%0d vector %0d", VREQ[i], i));
    end

    // R8 idle: no request gives cleared outputs
    issue(1'b0, 2'd1, 8'h90, 2'd0, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    check(11'h000, "R8 idle cycle");

    // R7 back-to-back requests
    issue(1'b1, 2'd1, 8'hA0, 2'd0, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    check({1'b1, 1'b0, 1'b1, 8'hA0}, "R7 back-to-back first");
    issue(1'b1, 2'd0, 8'h06, 2'd3, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    check({1'b1, 1'b1, 1'b0, 8'h1E}, "R7 back-to-back second");
    issue(1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    check(11'h000, "R7 result lasts one cycle");

    // R9 reserved after a valid result clears outputs
    issue(1'b1, 2'd2, 8'h00, 2'd0, 8'hC3, 8'h00);
    @(posedge clk); @(negedge clk);
    check({1'b1, 1'b1, 1'b0, 8'hC3}, "R6 indirect before reserved");
    issue(1'b1, 2'd3, 8'h12, 2'd1, 8'hC3, 8'h00);
    @(posedge clk); @(negedge clk);
    check(11'h000, "R9 reserved after result");

    // R1 reset with a pending request
    issue(1'b1, 2'd1, 8'hF0, 2'd0, 8'h00, 8'h00);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(11'h000, "R1 reset overrides request");
    rst = 1'b0;
    issue(1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    check(11'h000, "R1 after reset release");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule